// File: doc/BRIEF.md
# Narrow-Access Write-Combining Register Bridge

This bridge sits between a host bus that issues byte, halfword and word register accesses and an SD host register file that only takes aligned 32-bit transfers. A narrow read becomes one aligned word read. The addressed lane is then shifted down and zero-extended. A narrow write to an ordinary register becomes a read-modify-write of the containing word.

Halfword writes to the block-size, block-count and transfer-mode registers are not sent downstream. They are merged into two shadow words. When the command halfword is written, a pending block word is released first, followed by the combined transfer-mode/command word. Each of these is a single full-word write, so the slow-clock register file never receives two quick writes to the same word.

When the card clock is slow, the bridge inserts a settling gap after every downstream write. The gap is four card-clock periods rounded up to whole microseconds. It is a fixed 10 µs when the card clock is stopped (frequency zero). The gap is measured in system-clock cycles using a parameter that gives the number of cycles per microsecond.

Top module: `sdreg_narrow_bridge`

## Requirements
- R1: Every downstream access uses the word-aligned address (address bits 1:0 are zero).
- R2: A read returns the addressed lane of the aligned word, zero-extended into the low bits of up_rdata. The lane shift is 8 × (address bits 1:0) and the lane mask is 0xFF for a byte or 0xFFFF for a halfword. Sizes are coded 0 = byte, 1 = halfword, 2 = word. A word read returns the word unchanged.
- R3: A halfword write to block size (0x04) or block count (0x06) is merged into the block shadow word. It causes no downstream access.
- R4: A halfword write to transfer mode (0x0C) is merged into the low half of the command shadow word. It causes no downstream access.
- R5: A halfword write to the command register (0x0E) while the block shadow is nonzero does two things in order. First it writes the block shadow to word 0x04 and clears that shadow. Then it writes the command shadow, with the command value in bits 31:16, to word 0x0C.
- R6: A command halfword write while the block shadow is zero produces only the single write to word 0x0C. The command shadow keeps its transfer-mode content afterwards.
- R7: A byte write, or a halfword write to any other register, reads the aligned word, replaces only the addressed lane, and writes the whole word back.
- R8: A word write goes straight downstream as one write and changes neither shadow word.
- R9: When card_hz is nonzero and at most 400000, each downstream write is followed by ceil(4000000 / card_hz) microseconds with no downstream access. Above 400000 there is no gap.
- R10: When card_hz is zero, the gap after each downstream write is 10 µs.
- R11: After reset both shadow words are zero, up_ready is high and there is no downstream request.
- R12: up_ready is low from acceptance until completion. up_done is a one-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_hz | input | HZW | Current card clock frequency in Hz |
| up_req | input | 1 | Host request, accepted when up_ready is high |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_addr | input | AW | Byte address of the access |
| up_wdata | input | 32 | Write value; narrow values in the low bits |
| up_ready | output | 1 | Bridge idle and able to accept |
| up_done | output | 1 | One-cycle completion pulse |
| up_rdata | output | 32 | Read result, valid with up_done |
| dn_req | output | 1 | Downstream request, held until dn_ack |
| dn_we | output | 1 | Downstream write strobe |
| dn_addr | output | AW | Word-aligned downstream address |
| dn_wdata | output | 32 | Downstream write word |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read word, valid with dn_ack |

## Verification
The assertions assume a few things about the environment:
- the host only raises up_req when up_ready is high;
- halfword addresses are even;
- card_hz is stable for the whole of an access;
- the register file acknowledges a request in a later cycle and never acknowledges when no request is present.

The stimulus respects all of these. It waits for up_ready before each request, uses only even halfword offsets, changes card_hz only between accesses, and models the register file so that it acknowledges one cycle after each request. The gap checks compare the latency of the same access at a fast card clock and at a slow one, so the expected extra cycles follow directly from the microsecond count.

// File: rtl/sdreg_narrow_bridge.sv
`timescale 1ns/1ps
module sdreg_narrow_bridge #(
  parameter int AW = 8,
  parameter int CYC_PER_US = 200,
  parameter int SLOW_HZ = 400000,
  parameter int ZERO_US = 10,
  parameter int HZW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HZW-1:0] card_hz,
  input  logic           up_req,
  input  logic           up_we,
  input  logic [1:0]     up_size,
  input  logic [AW-1:0]  up_addr,
  input  logic [31:0]    up_wdata,
  output logic           up_ready,
  output logic           up_done,
  output logic [31:0]    up_rdata,
  output logic           dn_req,
  output logic           dn_we,
  output logic [AW-1:0]  dn_addr,
  output logic [31:0]    dn_wdata,
  input  logic           dn_ack,
  input  logic [31:0]    dn_rdata
);
  localparam int CW = $clog2(CYC_PER_US + 1);
  localparam int UW = $clog2(ZERO_US + 1);
  localparam logic [HZW:0]  GAP_UNITS = (HZW+1)'(4000000);
  localparam logic [AW-1:0] A_BSZ = AW'(8'h04);
  localparam logic [AW-1:0] A_BCNT = AW'(8'h06);
  localparam logic [AW-1:0] A_XMODE = AW'(8'h0C);
  localparam logic [AW-1:0] A_CMD = AW'(8'h0E);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WB, S_WR, S_GAP, S_DONE} st_t;

  function automatic logic [31:0] lane_merge(input logic [31:0] old, input logic [31:0] val,
                                             input logic half, input logic [1:0] off);
    logic [31:0] m;
    logic [4:0] sh;
    sh = {off, 3'b000};
    m = half ? 32'h0000_ffff : 32'h0000_00ff;
    return (old & ~(m << sh)) | ((val & m) << sh);
  endfunction

  st_t st;
  logic [31:0] blk_sh, cmd_sh, wd_q, rd_q;
  logic [AW-1:0] a_q;
  logic [1:0] sz_q;
  logic we_q, more;
  logic [CW-1:0] cyc;
  logic [UW-1:0] us;
  logic [HZW:0] accu;

  wire hw      = (up_size == 2'b01);
  wire is_blk  = hw && (up_addr == A_BSZ || up_addr == A_BCNT);
  wire is_xm   = hw && (up_addr == A_XMODE);
  wire is_cmd  = hw && (up_addr == A_CMD);
  wire gap_need = (card_hz <= HZW'(SLOW_HZ));
  wire [HZW:0] accu_nx = accu + (HZW+1)'(card_hz);
  wire gap_end = (card_hz == '0) ? ((us + 1'b1) >= UW'(ZERO_US)) : (accu_nx >= GAP_UNITS);
  wire [4:0] rsh = {a_q[1:0], 3'b000};
  wire [31:0] lane_rd = sz_q[1] ? dn_rdata :
                        ((dn_rdata >> rsh) & (sz_q[0] ? 32'h0000_ffff : 32'h0000_00ff));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      blk_sh <= '0;
      cmd_sh <= '0;
      wd_q <= '0;
      rd_q <= '0;
      a_q <= '0;
      sz_q <= '0;
      we_q <= 1'b0;
      more <= 1'b0;
      cyc <= '0;
      us <= '0;
      accu <= '0;
    end else begin
      case (st)
        S_IDLE: if (up_req) begin
          a_q <= up_addr;
          sz_q <= up_size;
          we_q <= up_we;
          wd_q <= up_wdata;
          if (!up_we) st <= S_RD;
          else if (up_size[1]) st <= S_WR;
          else if (is_blk) begin
            blk_sh <= lane_merge(blk_sh, up_wdata, 1'b1, up_addr[1:0]);
            st <= S_DONE;
          end else if (is_xm) begin
            cmd_sh <= lane_merge(cmd_sh, up_wdata, 1'b1, up_addr[1:0]);
            st <= S_DONE;
          end else if (is_cmd) begin
            wd_q <= lane_merge(cmd_sh, up_wdata, 1'b1, up_addr[1:0]);
            if (blk_sh != '0) begin
              more <= 1'b1;
              st <= S_WB;
            end else st <= S_WR;
          end else st <= S_RD;
        end
        S_RD: if (dn_ack) begin
          if (we_q) begin
            wd_q <= lane_merge(dn_rdata, wd_q, sz_q[0], a_q[1:0]);
            st <= S_WR;
          end else begin
            rd_q <= lane_rd;
            st <= S_DONE;
          end
        end
        S_WB, S_WR: if (dn_ack) begin
          if (st == S_WB) blk_sh <= '0;
          if (gap_need) begin
            st <= S_GAP;
            cyc <= '0;
            us <= '0;
            accu <= '0;
          end else if (more) begin
            more <= 1'b0;
            st <= S_WR;
          end else st <= S_DONE;
        end
        S_GAP: begin
          if (cyc == CW'(CYC_PER_US - 1)) begin
            cyc <= '0;
            us <= us + 1'b1;
            accu <= accu_nx;
            if (gap_end) begin
              more <= 1'b0;
              st <= more ? S_WR : S_DONE;
            end
          end else cyc <= cyc + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign up_ready = (st == S_IDLE);
  assign up_done  = (st == S_DONE);
  assign up_rdata = rd_q;
  assign dn_req   = (st == S_RD) || (st == S_WB) || (st == S_WR);
  assign dn_we    = (st == S_WB) || (st == S_WR);
  assign dn_addr  = (st == S_WB) ? A_BSZ : {a_q[AW-1:2], 2'b00};
  assign dn_wdata = (st == S_WB) ? blk_sh : wd_q;
endmodule

// File: rtl/sdreg_narrow_bridge_chk.sv
`timescale 1ns/1ps
module sdreg_narrow_bridge_chk #(
  parameter int AW = 8,
  parameter int SLOW_HZ = 400000,
  parameter int HZW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [HZW-1:0] card_hz,
  input logic           up_req,
  input logic           up_we,
  input logic [1:0]     up_size,
  input logic [AW-1:0]  up_addr,
  input logic           up_ready,
  input logic           up_done,
  input logic           dn_req,
  input logic           dn_we,
  input logic [AW-1:0]  dn_addr,
  input logic           dn_ack
);
  wire acc_hw_wr = up_req && up_ready && up_we && (up_size == 2'b01);

  // R1
  dn_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (dn_addr[1:0] == 2'b00));

  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> !up_ready);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |=> !up_done);

  // R3
  shadow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hw_wr && (up_addr == AW'(8'h04) || up_addr == AW'(8'h06) || up_addr == AW'(8'h0C)))
      |=> (up_done && !dn_req));

  // R5
  cmd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hw_wr && up_addr == AW'(8'h0E))
      |=> (dn_req && dn_we && (dn_addr == AW'(8'h04) || dn_addr == AW'(8'h0C))));

  // R9
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_we && dn_ack && card_hz <= HZW'(SLOW_HZ)) |=> !dn_req);
endmodule

bind sdreg_narrow_bridge sdreg_narrow_bridge_chk #(.AW(AW), .SLOW_HZ(SLOW_HZ), .HZW(HZW)) chk_i (
  .clk(clk), .rst_n(rst_n), .card_hz(card_hz), .up_req(up_req), .up_we(up_we),
  .up_size(up_size), .up_addr(up_addr), .up_ready(up_ready), .up_done(up_done),
  .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_ack(dn_ack));

// File: tb/sdreg_narrow_bridge_tb_top.sv
`timescale 1ns/1ps
module sdreg_narrow_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] card_hz = 32'd25000000;
  logic up_req = 1'b0, up_we = 1'b0;
  logic [1:0] up_size = 2'b00;
  logic [7:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic up_ready, up_done, dn_req, dn_we;
  logic [31:0] up_rdata, dn_wdata, dn_rdata;
  logic [7:0] dn_addr;
  logic dn_ack = 1'b0;

  logic [31:0] mem [0:63];
  logic [7:0]  wlog_a [0:255];
  logic [31:0] wlog_d [0:255];
  int wcnt = 0, misal = 0, busy_err = 0, pulse_err = 0;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sdreg_narrow_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .card_hz(card_hz), .up_req(up_req), .up_we(up_we),
    .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata), .up_ready(up_ready),
    .up_done(up_done), .up_rdata(up_rdata), .dn_req(dn_req), .dn_we(dn_we),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata));

  assign dn_rdata = mem[dn_addr[7:2]];

  always @(posedge clk) begin
    if (!rst_n) dn_ack <= 1'b0;
    else begin
      dn_ack <= dn_req && !dn_ack;
      if (dn_req && dn_addr[1:0] != 2'b00) misal <= misal + 1;
      if (dn_req && dn_we && dn_ack) begin
        mem[dn_addr[7:2]] <= dn_wdata;
        wlog_a[wcnt[7:0]] <= dn_addr;
        wlog_d[wcnt[7:0]] <= dn_wdata;
        wcnt <= wcnt + 1;
      end
    end
  end

  function automatic logic [31:0] pat(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h5A, b + 8'h11, ~b, b * 8'h03};
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] old, input logic [31:0] v,
                                     input int bytes, input int off);
    logic [31:0] m;
    m = (bytes == 2) ? 32'hffff : 32'hff;
    return (old & ~(m << (8 * off))) | ((v & m) << (8 * off));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [1:0] sz, input logic [7:0] a,
                      input logic [31:0] wd, output logic [31:0] rd, output int lat);
    while (!up_ready) @(negedge clk);
    up_req = 1'b1; up_we = we; up_size = sz; up_addr = a; up_wdata = wd;
    @(negedge clk);
    up_req = 1'b0;
    lat = 0;
    while (!up_done) begin
      if (up_ready) busy_err++;
      lat++;
      @(negedge clk);
    end
    rd = up_rdata;
    @(negedge clk);
    if (up_done) pulse_err++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd, ex;
    int lat, l0, lf, w0;
    for (int i = 0; i < 64; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(up_ready && !dn_req && !up_done, "R11", {29'd0, up_ready, dn_req, up_done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 read sweep over four words, every lane and size
    for (int w = 4; w < 8; w++) begin
      for (int o = 0; o < 4; o++) begin
        xfer(1'b0, 2'b00, 8'(4 * w + o), '0, rd, lat);
        ex = (pat(w) >> (8 * o)) & 32'hff;
        chk(rd == ex, "R2 byte", rd, ex);
      end
      for (int o = 0; o < 4; o += 2) begin
        xfer(1'b0, 2'b01, 8'(4 * w + o), '0, rd, lat);
        ex = (pat(w) >> (8 * o)) & 32'hffff;
        chk(rd == ex, "R2 half", rd, ex);
      end
      xfer(1'b0, 2'b10, 8'(4 * w), '0, rd, lat);
      chk(rd == pat(w), "R2 word", rd, pat(w));
    end

    // R11 / R6: shadows start at zero, so a command write is one plain write
    w0 = wcnt;
    xfer(1'b1, 2'b01, 8'h0E, 32'h00AB, rd, lat);
    chk(wcnt - w0 == 1, "R6 count", wcnt - w0, 1);
    chk(wlog_d[w0[7:0]] == 32'h00AB0000 && wlog_a[w0[7:0]] == 8'h0C, "R11 shadow zero",
        wlog_d[w0[7:0]], 32'h00AB0000);

    // R3 / R4 shadow writes stay inside the bridge
    w0 = wcnt;
    xfer(1'b1, 2'b01, 8'h04, 32'h0200, rd, lat);
    xfer(1'b1, 2'b01, 8'h06, 32'h0003, rd, lat);
    chk(wcnt == w0 && mem[1] == pat(1), "R3", mem[1], pat(1));
    xfer(1'b1, 2'b01, 8'h0C, 32'h0011, rd, lat);
    chk(wcnt == w0 && mem[3] == 32'h00AB0000, "R4", mem[3], 32'h00AB0000);

    // R5 command releases block word first, then command word
    xfer(1'b1, 2'b01, 8'h0E, 32'h1234, rd, lat);
    lf = lat;
    chk(wcnt - w0 == 2, "R5 count", wcnt - w0, 2);
    chk(wlog_a[w0[7:0]] == 8'h04 && wlog_d[w0[7:0]] == 32'h00030200, "R5 block", wlog_d[w0[7:0]], 32'h00030200);
    ex = 32'h12340011;
    chk(wlog_a[8'(w0 + 1)] == 8'h0C && wlog_d[8'(w0 + 1)] == ex, "R5 cmd", wlog_d[8'(w0 + 1)], ex);

    // R6 block shadow cleared, transfer mode retained
    w0 = wcnt;
    xfer(1'b1, 2'b01, 8'h0E, 32'h5678, rd, lat);
    chk(wcnt - w0 == 1 && wlog_d[w0[7:0]] == 32'h56780011, "R6", wlog_d[w0[7:0]], 32'h56780011);

    // R8 word writes pass through and leave both shadows untouched
    xfer(1'b1, 2'b01, 8'h06, 32'h0007, rd, lat);
    w0 = wcnt;
    xfer(1'b1, 2'b10, 8'h04, 32'hDEADBEEF, rd, lat);
    xfer(1'b1, 2'b10, 8'h0C, 32'hCAFE0000, rd, lat);
    chk(wcnt - w0 == 2 && mem[1] == 32'hDEADBEEF && mem[3] == 32'hCAFE0000, "R8 pass", mem[1], 32'hDEADBEEF);
    w0 = wcnt;
    xfer(1'b1, 2'b01, 8'h0E, 32'h0001, rd, lat);
    chk(wcnt - w0 == 2 && wlog_d[w0[7:0]] == 32'h00070000, "R8 blk kept", wlog_d[w0[7:0]], 32'h00070000);
    chk(wlog_d[8'(w0 + 1)] == 32'h00010011, "R8 cmd kept", wlog_d[8'(w0 + 1)], 32'h00010011);

    // R7 byte read-modify-write over every lane, and a halfword on another register
    for (int o = 0; o < 4; o++) begin
      ex = mrg(mem[8], 32'hC0 + o, 1, o);
      w0 = wcnt;
      xfer(1'b1, 2'b00, 8'(32 + o), 32'hFFFFFFC0 + o, rd, lat);
      chk(wcnt - w0 == 1 && mem[8] == ex, "R7 byte", mem[8], ex);
    end
    ex = mrg(mem[10], 32'hBEEF, 2, 2);
    w0 = wcnt;
    xfer(1'b1, 2'b01, 8'h2A, 32'h1234BEEF, rd, lat);
    chk(wcnt - w0 == 1 && mem[10] == ex, "R7 half", mem[10], ex);

    // R9 / R10 settling gap measured against a fast-clock baseline
    xfer(1'b1, 2'b10, 8'h30, 32'h1, rd, l0);
    card_hz = 32'd400000;
    xfer(1'b1, 2'b10, 8'h30, 32'h2, rd, lat);
    chk(lat == l0 + 10 * 200, "R9 400k", lat, l0 + 2000);
    card_hz = 32'd300000;
    xfer(1'b1, 2'b10, 8'h30, 32'h3, rd, lat);
    chk(lat == l0 + 14 * 200, "R9 300k", lat, l0 + 2800);
    card_hz = 32'd400001;
    xfer(1'b1, 2'b10, 8'h30, 32'h4, rd, lat);
    chk(lat == l0, "R9 fast", lat, l0);
    card_hz = 32'd0;
    xfer(1'b1, 2'b10, 8'h30, 32'h5, rd, lat);
    chk(lat == l0 + 10 * 200, "R10", lat, l0 + 2000);
    card_hz = 32'd400000;
    xfer(1'b1, 2'b01, 8'h04, 32'h0040, rd, lat);
    xfer(1'b1, 2'b01, 8'h0E, 32'h0002, rd, lat);
    chk(lat == lf + 2 * 2000, "R9 two writes", lat, lf + 4000);
    card_hz = 32'd25000000;

    // R1 / R12 observed through the whole run
    chk(misal == 0, "R1", misal, 0);
    chk(busy_err == 0, "R12 ready", busy_err, 0);
    chk(pulse_err == 0, "R12 pulse", pulse_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule